// File: doc/BRIEF.md
# Highway and Farm-Road Intersection Light Sequencer

This block drives the lamps at a crossing where a busy highway meets a lightly used farm road. The highway shows green by default. When a vehicle waits on the farm road, the highway turns yellow, then red, and the farm road gets a green. That green ends when the farm road is clear or when its maximum time runs out. The farm road then passes through yellow back to red, and the highway returns to green.

A single internal interval counter times every phase. The sequencer restarts it on each phase change, through a start strobe that is registered together with the phase. The counter reports a short expiry for the yellow phases and a long expiry for the green phases. Both interval lengths are parameters given in clock cycles. All durations below are counted in clock cycles from the rising edge that enters the phase. The lamp outputs are registered.

Top module: `crossing_light_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows highway green and farm red. The first highway green after reset is timed from the last rising edge at which `rst` was high.
- R2: Lamp codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. The value 2'b11 never appears on either output.
- R3: Highway green changes to highway yellow only at a rising edge where `car_waiting` is 1 and the green has already lasted at least `LONG_CYC` cycles. That change happens at the first such edge. With no car present, highway green holds indefinitely.
- R4: Highway yellow lasts exactly `SHORT_CYC` cycles, whatever `car_waiting` does meanwhile, and is followed by farm green.
- R5: Farm green ends at the first rising edge where `car_waiting` is 0, or after `LONG_CYC` cycles, whichever comes first. It is followed by farm yellow.
- R6: Farm yellow lasts exactly `SHORT_CYC` cycles and is followed by highway green with farm red.
- R7: At least one of the two roads shows red in every cycle.
- R8: Every highway green lasts at least `LONG_CYC` cycles, including one that follows farm yellow while a car waits continuously, because the interval counter restarts on every phase change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| car_waiting | input | 1 | Vehicle-present sensor on the farm road, sampled each rising edge |
| hwy_lamp | output | 2 | Highway lamp code (00 green, 01 yellow, 10 red) |
| farm_lamp | output | 2 | Farm-road lamp code (00 green, 01 yellow, 10 red) |

## Verification
The properties assume that `car_waiting` is a clean synchronous level, that reset is held for at least two edges at start-up, and that `SHORT_CYC` is at least 2 and below `LONG_CYC`. The checker measures how long each phase lasts with its own saturating counter, so the phase limits are enforced without long delays. The stimulus changes the sensor only at falling clock edges, and it holds reset for three edges. The sensor is raised or dropped at chosen offsets from phase entry: before and after the minimum green, during a yellow, and in the first cycle of a farm green. This way every phase length the bench expects is fixed by the requirements.

// File: rtl/tlc_pkg.sv
`timescale 1ns/1ps
package tlc_pkg;
  typedef enum logic [1:0] {
    LAMP_GREEN  = 2'b00,
    LAMP_YELLOW = 2'b01,
    LAMP_RED    = 2'b10
  } lamp_t;

  typedef enum logic [1:0] {
    PH_HWY_GO,
    PH_HWY_WARN,
    PH_FARM_GO,
    PH_FARM_WARN
  } phase_t;
endpackage

// File: rtl/tlc_interval_timer.sv
`timescale 1ns/1ps
module tlc_interval_timer #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYC - 1);

  logic [CW-1:0] elapsed_q;

  // The restart strobe is high in the first cycle of a phase, so the count
  // reads 1 in the second cycle and k after k edges into the phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
    end else if (restart) begin
      elapsed_q <= CW'(1);
    end else if (elapsed_q != LONG_LIM) begin
      elapsed_q <= elapsed_q + CW'(1);
    end
  end

  // Hide a stale count during the restart cycle.
  assign short_done = !restart && (elapsed_q >= SHORT_LIM);
  assign long_done  = !restart && (elapsed_q >= LONG_LIM);
endmodule

// File: rtl/tlc_sequencer.sv
`timescale 1ns/1ps
module tlc_sequencer
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase_nxt,
  output logic   restart_q
);
  phase_t phase_q;
  logic   start_nxt;

  always_comb begin
    phase_nxt = phase_q;
    start_nxt = 1'b0;
    case (phase_q)
      PH_HWY_GO:    if (long_done && car)  begin phase_nxt = PH_HWY_WARN;  start_nxt = 1'b1; end
      PH_HWY_WARN:  if (short_done)        begin phase_nxt = PH_FARM_GO;   start_nxt = 1'b1; end
      PH_FARM_GO:   if (long_done || !car) begin phase_nxt = PH_FARM_WARN; start_nxt = 1'b1; end
      PH_FARM_WARN: if (short_done)        begin phase_nxt = PH_HWY_GO;    start_nxt = 1'b1; end
      default:                             begin phase_nxt = PH_HWY_GO;    start_nxt = 1'b1; end
    endcase
  end

  // Reset counts as a start, so the first highway green is timed from it.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_HWY_GO;
      restart_q <= 1'b1;
    end else begin
      phase_q   <= phase_nxt;
      restart_q <= start_nxt;
    end
  end
endmodule

// File: rtl/tlc_lamp_reg.sv
`timescale 1ns/1ps
module tlc_lamp_reg
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_nxt,
  output lamp_t  hwy_q,
  output lamp_t  farm_q
);
  lamp_t hwy_d, farm_d;

  always_comb begin
    hwy_d  = LAMP_RED;
    farm_d = LAMP_RED;
    case (phase_nxt)
      PH_HWY_GO:    hwy_d  = LAMP_GREEN;
      PH_HWY_WARN:  hwy_d  = LAMP_YELLOW;
      PH_FARM_GO:   farm_d = LAMP_GREEN;
      PH_FARM_WARN: farm_d = LAMP_YELLOW;
      default:      hwy_d  = LAMP_GREEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hwy_q  <= LAMP_GREEN;
      farm_q <= LAMP_RED;
    end else begin
      hwy_q  <= hwy_d;
      farm_q <= farm_d;
    end
  end
endmodule

// File: rtl/crossing_light_ctrl.sv
`timescale 1ns/1ps
module crossing_light_ctrl
  import tlc_pkg::*;
#(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_waiting,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);
  logic   restart, short_done, long_done;
  phase_t phase_nxt;
  lamp_t  hwy_q, farm_q;

  tlc_interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(restart),
    .short_done(short_done), .long_done(long_done)
  );

  tlc_sequencer u_seq (
    .clk(clk), .rst(rst), .car(car_waiting),
    .short_done(short_done), .long_done(long_done),
    .phase_nxt(phase_nxt), .restart_q(restart)
  );

  tlc_lamp_reg u_lamps (
    .clk(clk), .rst(rst), .phase_nxt(phase_nxt),
    .hwy_q(hwy_q), .farm_q(farm_q)
  );

  assign hwy_lamp  = hwy_q;
  assign farm_lamp = farm_q;
endmodule

// File: rtl/tlc_checker.sv
`timescale 1ns/1ps
module tlc_checker #(
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       car,
  input logic [1:0] hwy,
  input logic [1:0] farm
);
  localparam logic [1:0] GRN = 2'b00;
  localparam logic [1:0] YEL = 2'b01;
  localparam logic [1:0] RD  = 2'b10;
  localparam int DW = $clog2(LONG_CYC + 1);
  localparam logic [DW-1:0] S_LAST = DW'(SHORT_CYC - 1);
  localparam logic [DW-1:0] L_LAST = DW'(LONG_CYC - 1);
  localparam logic [DW-1:0] D_CAP  = DW'(LONG_CYC);

  // Cycles spent in the current lamp pair, 0 in the first cycle of a phase.
  logic [1:0]    prev_h, prev_f;
  logic [DW-1:0] run_q, dwell;
  logic          fresh_q;

  always_comb begin
    if (fresh_q || hwy != prev_h || farm != prev_f) dwell = '0;
    else if (run_q == D_CAP)                         dwell = run_q;
    else                                             dwell = run_q + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b1;
      run_q   <= '0;
      prev_h  <= GRN;
      prev_f  <= RD;
    end else begin
      fresh_q <= 1'b0;
      run_q   <= dwell;
      prev_h  <= hwy;
      prev_f  <= farm;
    end
  end

  AST_RESET_LAMPS: assert property (@(posedge clk) rst |=> (hwy == GRN && farm == RD)); // R1
  AST_LAMP_CODE: assert property (@(posedge clk) disable iff (rst) (hwy != 2'b11 && farm != 2'b11)); // R2
  AST_HWY_MIN_GREEN: assert property (@(posedge clk) disable iff (rst) ($past(hwy) == GRN && hwy != GRN) |-> ($past(dwell) >= L_LAST)); // R3
  AST_HWY_LEAVE_CAR: assert property (@(posedge clk) disable iff (rst) ($past(hwy) == GRN && hwy == YEL) |-> $past(car)); // R3
  AST_HWY_YEL_LEN: assert property (@(posedge clk) disable iff (rst) ($past(hwy) == YEL && hwy != YEL) |-> ($past(dwell) == S_LAST)); // R4
  AST_HWY_YEL_MAX: assert property (@(posedge clk) disable iff (rst) (hwy == YEL) |-> (dwell <= S_LAST)); // R4
  AST_HWY_YEL_NEXT: assert property (@(posedge clk) disable iff (rst) ($past(hwy) == YEL && hwy != YEL) |-> (hwy == RD && farm == GRN)); // R4
  AST_FARM_GRN_MAX: assert property (@(posedge clk) disable iff (rst) (farm == GRN) |-> (dwell <= L_LAST)); // R5
  AST_FARM_GRN_DROP: assert property (@(posedge clk) disable iff (rst) (farm == GRN && !car) |=> (farm == YEL)); // R5
  AST_FARM_YEL_LEN: assert property (@(posedge clk) disable iff (rst) ($past(farm) == YEL && farm != YEL) |-> ($past(dwell) == S_LAST)); // R6
  AST_FARM_YEL_NEXT: assert property (@(posedge clk) disable iff (rst) ($past(farm) == YEL && farm != YEL) |-> (hwy == GRN && farm == RD)); // R6
  AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (rst) (hwy == RD || farm == RD)); // R7
endmodule

bind crossing_light_ctrl tlc_checker #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tlc_chk (
  .clk(clk), .rst(rst), .car(car_waiting), .hwy(hwy_lamp), .farm(farm_lamp)
);

// File: tb/crossing_light_ctrl_bench.sv
`timescale 1ns/1ps
module crossing_light_ctrl_bench;
  localparam int SC = 3;
  localparam int LC = 8;
  localparam logic [1:0] GRN = 2'b00;
  localparam logic [1:0] YEL = 2'b01;
  localparam logic [1:0] RD  = 2'b10;

  typedef struct {
    logic [1:0] h;
    logic [1:0] f;
    int         len;
    string      req;
  } phase_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car = 1'b0;
  logic [1:0] hwy, farm;
  int checks = 0;
  int errors = 0;
  phase_item_t exp_q[$];

  always #4 clk = ~clk;

  crossing_light_ctrl #(.SHORT_CYC(SC), .LONG_CYC(LC)) u_crossing_light_ctrl (
    .clk(clk), .rst(rst), .car_waiting(car), .hwy_lamp(hwy), .farm_lamp(farm)
  );

  task automatic push_phase(input logic [1:0] h, input logic [1:0] f, input int len, input string req);
    phase_item_t it;
    it.h = h; it.f = f; it.len = len; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic wait_lamps(input logic [1:0] h, input logic [1:0] f);
    do begin
      @(posedge clk); #2;
    end while (!(hwy == h && farm == f));
  endtask

  // Monitor: measures each lamp phase and compares it with the scoreboard.
  logic [1:0] cur_h, cur_f;
  int run;
  always begin
    @(posedge clk); #2;
    if (rst) begin
      cur_h = hwy; cur_f = farm; run = 1;
    end else begin
      checks++;
      if (hwy != RD && farm != RD) begin
        errors++;
        $display("FAIL R7: hwy=%b farm=%b expected one red", hwy, farm);
      end
      checks++;
      if (hwy == 2'b11 || farm == 2'b11) begin
        errors++;
        $display("FAIL R2: hwy=%b farm=%b expected no 11 code", hwy, farm);
      end
      if (hwy == cur_h && farm == cur_f) begin
        run++;
      end else begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3: unexpected phase h=%b f=%b len=%0d, expected none", cur_h, cur_f, run);
        end else begin
          phase_item_t it;
          it = exp_q.pop_front();
          if (it.h != cur_h || it.f != cur_f || it.len != run) begin
            errors++;
            $display("FAIL %s: phase h=%b f=%b len=%0d, expected h=%b f=%b len=%0d",
                     it.req, cur_h, cur_f, run, it.h, it.f, it.len);
          end
        end
        cur_h = hwy; cur_f = farm; run = 1;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Expected phase sequence (S=3, L=8)
    push_phase(GRN, RD, 15, "R1");   // first green, car raised late
    push_phase(YEL, RD, SC, "R4");
    push_phase(RD, GRN, LC, "R5");   // car held: long timeout
    push_phase(RD, YEL, SC, "R6");
    push_phase(GRN, RD, LC, "R8");   // car waiting throughout
    push_phase(YEL, RD, SC, "R4");   // car dropped during yellow
    push_phase(RD, GRN, 1, "R5");    // no car at entry
    push_phase(RD, YEL, SC, "R6");
    push_phase(GRN, RD, LC, "R3");   // car arrives early
    push_phase(YEL, RD, SC, "R4");
    push_phase(RD, GRN, 3, "R5");    // car leaves early
    push_phase(RD, YEL, SC, "R6");
    push_phase(GRN, RD, 12, "R3");   // car arrives late
    push_phase(YEL, RD, SC, "R4");
    push_phase(RD, GRN, LC, "R5");
    push_phase(RD, YEL, SC, "R6");

    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (hwy != GRN || farm != RD) begin
      errors++;
      $display("FAIL R1: reset lamps h=%b f=%b, expected h=00 f=10", hwy, farm);
    end
    @(negedge clk) rst = 1'b0;

    repeat (14) @(posedge clk);
    @(negedge clk) car = 1'b1;
    wait_lamps(YEL, RD);
    wait_lamps(RD, GRN);
    wait_lamps(GRN, RD);
    wait_lamps(YEL, RD);
    @(negedge clk) car = 1'b0;
    wait_lamps(GRN, RD);
    repeat (2) @(posedge clk);
    @(negedge clk) car = 1'b1;
    wait_lamps(RD, GRN);
    repeat (2) @(posedge clk);
    @(negedge clk) car = 1'b0;
    wait_lamps(GRN, RD);
    repeat (11) @(posedge clk);
    @(negedge clk) car = 1'b1;
    wait_lamps(RD, GRN);
    wait_lamps(GRN, RD);
    @(negedge clk) car = 1'b0;
    repeat (20) @(posedge clk);
    #2;
    checks++;
    if (hwy != GRN || farm != RD) begin
      errors++;
      $display("FAIL R3: idle lamps h=%b f=%b, expected h=00 f=10", hwy, farm);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d phases missing, expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule